// File: doc/BRIEF.md
# Interrupt Source Polling Controller

This controller sits on the master side of a shared peripheral bus. Many slaves can request attention by pulling one common open-drain pending line low. A single request line reaches the master only through the slave that is currently selected. The controller therefore has to find out which slave asked for service. It watches the pending line. When it goes low, the controller raises select and steps through the eight slave addresses one at a time. At each address it waits for a settle time and then samples the request line. When it finds a requester, it reports that address on a found/done handshake, and the service logic completes the transaction. The controller then drops select and looks at the pending line again. If the line is still low, another slave is waiting, and the scan continues from the address after the one just served.

The scan is round-robin across service episodes, so a slave at a low address cannot starve the higher ones. If a full pass over all eight addresses finds nobody while pending is still low, the controller pulses an error flag and goes back to idle. A request seen while select is low cannot come from a polled slave, so it is flagged as a foreign interrupt instead.

States: `ST_IDLE` (select low, waiting for pending low), `ST_SETTLE` (address and select driven, settle timer running), `ST_PROBE` (request line sampled), `ST_SERVE` (found raised, waiting for done), `ST_RECHECK` (select low, pending line tested), `ST_FAULT` (one-cycle error pulse). Transitions:
- IDLE→SETTLE on pending low.
- SETTLE→PROBE when the timer expires.
- PROBE→SERVE on request high.
- PROBE→SETTLE on request low, moving to the next address.
- PROBE→FAULT on request low at the eighth probe.
- SERVE→RECHECK on done.
- RECHECK→SETTLE on pending low.
- RECHECK→IDLE on pending high.
- FAULT→IDLE always.

Top module: `irq_poll_master`

## Requirements
- R1: After reset, `sel_o`, `found_o`, `scan_err_o` and `foreign_o` are low and `addr_o` is 0. While `pend_n` stays high, `sel_o` stays low.
- R2: If `pend_n` is low in the idle state, `sel_o` is high in the next cycle, with `addr_o` equal to the scan cursor (0 after reset).
- R3: The request line is sampled only after the address has been held with select high for SETTLE+1 cycles. From the cycle in which `pend_n` first goes low, `found_o` rises 1+(d+1)·(SETTLE+2) cycles later, where d is the distance modulo 8 from the cursor to the requester.
- R4: While `sel_o` stays high, `addr_o` only changes to its previous value plus one, modulo 8.
- R5: When `req_i` is sampled high, `found_o` goes high with `sel_o` high. `found_o` and `addr_o` then hold until `svc_done_i` is seen high.
- R6: In the cycle after `svc_done_i` is accepted, `found_o` and `sel_o` are low. If `pend_n` is low in that cycle, scanning resumes at the served address plus one and reaches a requester at distance d after 2+(d+1)·(SETTLE+2) cycles. Otherwise the controller returns to idle.
- R7: Several requesters in one pending episode are each served once, in ascending address order (modulo 8) starting from the cursor. The cursor is left at the last served address plus one.
- R8: If eight consecutive probes find no requester, `scan_err_o` pulses high for one cycle with `sel_o` low, 1+8·(SETTLE+2) cycles after the scan began. The next scan starts from the same address.
- R9: `req_i` high while `sel_o` is low sets `foreign_o` high in the next cycle and does not start a scan. `foreign_o` is low in any cycle that follows a cycle with `sel_o` high.
- R10: `svc_done_i` has no effect unless `found_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_n | input | 1 | Shared pending line, low when any slave requests |
| req_i | input | 1 | Request line from the selected slave |
| svc_done_i | input | 1 | Service logic finished with the found slave |
| sel_o | output | 1 | Slave select |
| addr_o | output | ADDR_W | Slave address being polled or served |
| found_o | output | 1 | Requester located at `addr_o` |
| scan_err_o | output | 1 | Full scan found no requester |
| foreign_o | output | 1 | Request seen while no slave was selected |

## Verification
On every cycle, the assertions check the following:
- the +1 address stepping under select;
- the settle time before any find;
- that found is held stable until done;
- that select and found are released right after done;
- that select only starts after pending was low;
- the single-cycle error pulse;
- the foreign flag rule.

Some properties depend on the set of slaves that are requesting, so only the bench scenarios can show them:
- the service order;
- the round-robin start point across episodes;
- that the cursor stays put after a failed scan;
- the exact find latencies.

The bench runs these over every non-empty requester mask.

// File: rtl/poll_pkg.sv
`timescale 1ns/1ps
package poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_PROBE,
        ST_SERVE,
        ST_RECHECK,
        ST_FAULT
    } poll_state_t;
endpackage

// File: rtl/poll_settle_timer.sv
`timescale 1ns/1ps
module poll_settle_timer #(
    parameter int SETTLE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int CW = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);

    logic [CW-1:0] cnt_q;

    assign expired = (cnt_q == CW'(SETTLE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/poll_cursor.sv
`timescale 1ns/1ps
module poll_cursor #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_probes,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last_probe
);
    localparam int NSLOT = 1 << ADDR_W;

    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] probes_q;

    assign addr       = cur_q;
    assign last_probe = (probes_q == ADDR_W'(NSLOT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            probes_q <= '0;
        end else begin
            if (step) begin
                cur_q <= cur_q + 1'b1;
            end
            if (clr_probes) begin
                probes_q <= '0;
            end else if (step) begin
                probes_q <= probes_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/poll_fsm.sv
`timescale 1ns/1ps
module poll_fsm
    import poll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_n,
    input  logic req,
    input  logic done,
    input  logic settle_expired,
    input  logic last_probe,
    output logic sel,
    output logic found,
    output logic scan_err,
    output logic timer_clr,
    output logic cursor_step,
    output logic probes_clr
);
    poll_state_t state_q;
    poll_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!pend_n) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_expired) state_d = ST_PROBE;
            end
            ST_PROBE: begin
                if (req)             state_d = ST_SERVE;
                else if (last_probe) state_d = ST_FAULT;
                else                 state_d = ST_SETTLE;
            end
            ST_SERVE: begin
                if (done) state_d = ST_RECHECK;
            end
            ST_RECHECK: begin
                state_d = pend_n ? ST_IDLE : ST_SETTLE;
            end
            ST_FAULT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sel         = 1'b0;
        found       = 1'b0;
        scan_err    = 1'b0;
        timer_clr   = 1'b1;
        cursor_step = 1'b0;
        probes_clr  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                probes_clr = 1'b1;
            end
            ST_SETTLE: begin
                sel       = 1'b1;
                timer_clr = 1'b0;
            end
            ST_PROBE: begin
                sel         = 1'b1;
                cursor_step = !req;
            end
            ST_SERVE: begin
                sel         = 1'b1;
                found       = 1'b1;
                cursor_step = done;
            end
            ST_RECHECK: begin
                probes_clr = 1'b1;
            end
            ST_FAULT: begin
                scan_err = 1'b1;
            end
            default: begin
                probes_clr = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/irq_poll_master.sv
`timescale 1ns/1ps
module irq_poll_master #(
    parameter int ADDR_W = 3,
    parameter int SETTLE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_n,
    input  logic              req_i,
    input  logic              svc_done_i,
    output logic              sel_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              found_o,
    output logic              scan_err_o,
    output logic              foreign_o
);
    logic settle_expired;
    logic timer_clr;
    logic cursor_step;
    logic probes_clr;
    logic last_probe;
    logic foreign_q;

    poll_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .pend_n         (pend_n),
        .req            (req_i),
        .done           (svc_done_i),
        .settle_expired (settle_expired),
        .last_probe     (last_probe),
        .sel            (sel_o),
        .found          (found_o),
        .scan_err       (scan_err_o),
        .timer_clr      (timer_clr),
        .cursor_step    (cursor_step),
        .probes_clr     (probes_clr)
    );

    poll_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (timer_clr),
        .expired (settle_expired)
    );

    poll_cursor #(.ADDR_W(ADDR_W)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_probes (probes_clr),
        .step       (cursor_step),
        .addr       (addr_o),
        .last_probe (last_probe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreign_q <= 1'b0;
        end else begin
            foreign_q <= !sel_o && req_i;
        end
    end

    assign foreign_o = foreign_q;
endmodule

// File: rtl/poll_checker.sv
`timescale 1ns/1ps
module poll_checker #(
    parameter int ADDR_W = 3,
    parameter int SETTLE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pend_n,
    input logic              req_i,
    input logic              svc_done_i,
    input logic              sel_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              found_o,
    input logic              scan_err_o,
    input logic              foreign_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            stab_q <= '0;
        end else begin
            addr_q <= addr_o;
            if (!sel_o || addr_o != addr_q) stab_q <= '0;
            else if (stab_q != '1)          stab_q <= stab_q + 1'b1;
        end
    end

    p_start_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> $past(!pend_n));

    p_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found_o) |-> (stab_q >= 32'(SETTLE + 1)));

    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && $past(sel_o) && addr_o != $past(addr_o))
            |-> addr_o == ADDR_W'($past(addr_o) + 1'b1));

    p_found_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> sel_o);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && !svc_done_i) |=> (found_o && $stable(addr_o)));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && svc_done_i) |=> (!found_o && !sel_o));

    p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_err_o |=> !scan_err_o);

    p_foreign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_o && req_i) |=> foreign_o);

    p_no_foreign_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |=> !foreign_o);
endmodule

bind irq_poll_master poll_checker #(.ADDR_W(ADDR_W), .SETTLE(SETTLE)) i_poll_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_n     (pend_n),
    .req_i      (req_i),
    .svc_done_i (svc_done_i),
    .sel_o      (sel_o),
    .addr_o     (addr_o),
    .found_o    (found_o),
    .scan_err_o (scan_err_o),
    .foreign_o  (foreign_o)
);

// File: tb/test_irq_poll_master.sv
`timescale 1ns/1ps
module test_irq_poll_master;
    localparam int ADDR_W = 3;
    localparam int SETTLE = 2;
    localparam int NSLOT  = 1 << ADDR_W;
    localparam int SLOT   = SETTLE + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pend_n;
    logic              req_i;
    logic              svc_done_i = 1'b0;
    logic              sel_o;
    logic [ADDR_W-1:0] addr_o;
    logic              found_o;
    logic              scan_err_o;
    logic              foreign_o;

    logic [NSLOT-1:0]  reqset = '0;
    logic              pend_force = 1'b0;
    logic              foreign_drv = 1'b0;

    int checks = 0;
    int errors = 0;
    int exp_cur = 0;

    always #4 clk = ~clk;

    assign pend_n = !((|reqset) || pend_force);
    assign req_i  = (sel_o && reqset[addr_o]) || foreign_drv;

    irq_poll_master #(.ADDR_W(ADDR_W), .SETTLE(SETTLE)) i_irq_poll_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_n     (pend_n),
        .req_i      (req_i),
        .svc_done_i (svc_done_i),
        .sel_o      (sel_o),
        .addr_o     (addr_o),
        .found_o    (found_o),
        .scan_err_o (scan_err_o),
        .foreign_o  (foreign_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_episode(input logic [NSLOT-1:0] mask);
        logic [NSLOT-1:0] pending;
        int n;
        int d;
        int exp_a;
        int exp_lat;
        bit first;
        pending = mask;
        reqset  = mask;
        first   = 1'b1;
        tick();
        n = 1;
        chk(sel_o && addr_o == exp_cur[ADDR_W-1:0], "R2 scan start", int'(addr_o), exp_cur);
        while (pending != '0) begin
            d = 0;
            for (int k = 0; k < NSLOT; k++) begin
                if (pending[(exp_cur + k) % NSLOT]) begin
                    d = k;
                    break;
                end
            end
            exp_a   = (exp_cur + d) % NSLOT;
            exp_lat = (first ? 1 : 2) + (d + 1) * SLOT;
            while (!found_o && n < 400) begin
                tick();
                n++;
            end
            chk(n == exp_lat, first ? "R3 find latency" : "R6 resume latency", n, exp_lat);
            chk(found_o && sel_o, "R5 found with select", int'(found_o), 1);
            chk(int'(addr_o) == exp_a, "R7 service order", int'(addr_o), exp_a);
            tick();
            chk(found_o && int'(addr_o) == exp_a, "R5 hold until done", int'(addr_o), exp_a);
            svc_done_i = 1'b1;
            pending[exp_a] = 1'b0;
            reqset = pending;
            @(posedge clk);
            @(negedge clk);
            svc_done_i = 1'b0;
            n = 1;
            chk(!sel_o && !found_o, "R6 release after done", int'(sel_o), 0);
            exp_cur = (exp_a + 1) % NSLOT;
            first = 1'b0;
        end
        tick();
        tick();
        chk(!sel_o, "R6 idle after pending clears", int'(sel_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(!sel_o && !found_o && !scan_err_o && !foreign_o, "R1 reset outputs", int'(sel_o), 0);
        chk(addr_o == '0, "R1 reset address", int'(addr_o), 0);
        repeat (3) tick();
        chk(!sel_o, "R1 idle without pending", int'(sel_o), 0);

        // R10: done while nothing is found
        svc_done_i = 1'b1;
        tick();
        svc_done_i = 1'b0;
        tick();
        chk(!sel_o && !found_o && addr_o == '0, "R10 stray done ignored", int'(addr_o), 0);

        // R9: foreign request while idle
        foreign_drv = 1'b1;
        tick();
        chk(foreign_o == 1'b1, "R9 foreign flagged", int'(foreign_o), 1);
        chk(!sel_o, "R9 no scan on foreign", int'(sel_o), 0);
        foreign_drv = 1'b0;
        tick();
        chk(foreign_o == 1'b0, "R9 foreign clears", int'(foreign_o), 0);

        // R10 continued: cursor untouched, slot 0 found at distance 0
        run_episode(8'h01);

        // R7: every non-empty requester set
        for (int m = 1; m < (1 << NSLOT); m++) begin
            run_episode(NSLOT'(m));
        end

        // R8: pending low with no requester
        pend_force = 1'b1;
        n = 0;
        while (!scan_err_o && n < 400) begin
            tick();
            n++;
        end
        chk(n == 1 + NSLOT * SLOT, "R8 fault latency", n, 1 + NSLOT * SLOT);
        chk(scan_err_o && !sel_o, "R8 error with select low", int'(sel_o), 0);
        pend_force = 1'b0;
        tick();
        chk(!scan_err_o, "R8 single pulse", int'(scan_err_o), 0);
        tick();
        run_episode(NSLOT'(1) << exp_cur);
        run_episode(NSLOT'(1) << ((exp_cur + 3) % NSLOT));

        summary();
    end
endmodule